// File: doc/BRIEF.md
# Segmented Two-Level Page Walker

This block turns a logical address into a physical one in two steps. The logical address has a 13-bit segment selector and a 32-bit offset. The first step reads a descriptor from a segment table in memory. The second step walks a two-level page table to find the page frame.

The caller supplies three table pointers as inputs:

- the base address of the segment table;
- the highest legal selector;
- the base address of the page directory.

All table reads share one memory read port. There is never more than one read outstanding at a time. A read request is a one-cycle strobe, and the data returns with a valid strobe after any number of cycles.

Each walk ends in one of two ways:

- a one-cycle completion pulse, with the physical address;
- a one-cycle fault pulse, with a code that says which stage stopped the walk.

Top module: `seg_page_walker`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fault` and `mem_rd_en` are all low, and `fault_code` is 0.
- R2: A request whose selector is strictly greater than `seg_tbl_len` ends with fault code 1 (trap) and makes no memory read. A selector equal to `seg_tbl_len` is legal.
- R3: A segment descriptor is two 32-bit words at `seg_tbl_base + 8*sel`. The limit word comes first and the base word is at +4. The limit is read first. An offset strictly greater than the limit ends the walk with fault code 2, after exactly one read. An offset equal to the limit is legal.
- R4: The linear address is the descriptor base plus the offset, modulo 2^32.
- R5: Bits 31:22 of the linear address index the outer table. The outer entry is read at `dir_base + 4*index`. If bit 0 (present) of that entry is clear, the walk ends with fault code 3 after three reads.
- R6: The inner table base is the outer entry with bits 11:0 cleared. Bits 21:12 of the linear address index the inner entry, which is read at `inner_base + 4*index`. If bit 0 of that entry is clear, the walk ends with fault code 4 after four reads.
- R7: A walk that succeeds takes four reads and gives `phys_addr = {inner_entry[31:12], linear[11:0]}`. It raises `done` for exactly one cycle, with `fault` low.
- R8: `mem_rd_en` is a one-cycle pulse. No new read is issued until `mem_rd_valid` has returned the previous read.
- R9: `busy` is high from the cycle after a request is accepted until the cycle that holds the result pulse, and low after it. `req_valid` is ignored while `busy` is high.
- R10: `done` and `fault` are never high together, and each lasts one cycle. `fault_code` is 0 whenever `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_sel | input | 13 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| seg_tbl_base | input | 32 | Byte address of the segment table |
| seg_tbl_len | input | 13 | Highest legal selector |
| dir_base | input | 32 | Byte address of the outer page table |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| fault | output | 1 | Walk aborted (one-cycle pulse) |
| fault_code | output | 3 | 1 trap, 2 segment limit, 3 outer not present, 4 inner not present |
| phys_addr | output | 32 | Physical address, valid with `done` |

## Verification
The bench builds the block with its default widths: 13-bit selector, 32-bit addresses, 10-bit indices and 4 KiB pages. With these values the bench can reach both equality boundaries, selector equal to the length and offset equal to the limit. It can also make the base-plus-offset sum wrap past 2^32. A sparse bench memory model answers reads after either one or three cycles. That exposes both back-to-back and stretched read handshakes. A stray request sent during a walk checks that extra requests are dropped.

// File: rtl/seg_page_walker.sv
module seg_page_walker #(
  parameter int SEL_W = 13,
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int PG_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [AW-1:0]    req_off,
  input  logic [AW-1:0]    seg_tbl_base,
  input  logic [SEL_W-1:0] seg_tbl_len,
  input  logic [AW-1:0]    dir_base,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [AW-1:0]    mem_rd_data,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [2:0]       fault_code,
  output logic [AW-1:0]    phys_addr
);
  localparam int DESC_SH = 3;
  localparam int PTE_SH  = 2;
  localparam int OUT_LSB = PG_W + IDX_W;

  localparam logic [2:0] FC_NONE  = 3'd0;
  localparam logic [2:0] FC_TRAP  = 3'd1;
  localparam logic [2:0] FC_LIMIT = 3'd2;
  localparam logic [2:0] FC_NP_O  = 3'd3;
  localparam logic [2:0] FC_NP_I  = 3'd4;

  typedef enum logic [2:0] {
    W_IDLE, W_LIMIT, W_BASE, W_OUTER, W_INNER, W_DONE
  } walk_t;

  walk_t            st;
  logic [SEL_W-1:0] sel_q;
  logic [AW-1:0]    off_q;
  logic [AW-1:0]    lin_q;
  logic [AW-1:0]    tbl_q;
  logic [AW-1:0]    pa_q;
  logic [2:0]       fc_q;
  logic             pend;

  logic [AW-1:0] desc_addr;
  logic [AW-1:0] outer_addr;
  logic [AW-1:0] inner_addr;
  logic          reading;
  logic          got;

  assign desc_addr  = seg_tbl_base + (AW'(sel_q) << DESC_SH);
  assign outer_addr = dir_base + (AW'(lin_q[OUT_LSB +: IDX_W]) << PTE_SH);
  assign inner_addr = tbl_q + (AW'(lin_q[PG_W +: IDX_W]) << PTE_SH);

  assign reading   = (st == W_LIMIT) || (st == W_BASE) ||
                     (st == W_OUTER) || (st == W_INNER);
  assign got       = reading && pend && mem_rd_valid;
  assign mem_rd_en = reading && !pend;

  always_comb begin
    case (st)
      W_LIMIT: mem_rd_addr = desc_addr;
      W_BASE:  mem_rd_addr = desc_addr + AW'(4);
      W_OUTER: mem_rd_addr = outer_addr;
      W_INNER: mem_rd_addr = inner_addr;
      default: mem_rd_addr = '0;
    endcase
  end

  assign busy       = (st != W_IDLE);
  assign done       = (st == W_DONE) && (fc_q == FC_NONE);
  assign fault      = (st == W_DONE) && (fc_q != FC_NONE);
  assign fault_code = fault ? fc_q : FC_NONE;
  assign phys_addr  = pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_IDLE;
      sel_q <= '0;
      off_q <= '0;
      lin_q <= '0;
      tbl_q <= '0;
      pa_q  <= '0;
      fc_q  <= FC_NONE;
      pend  <= 1'b0;
    end else begin
      if (mem_rd_en) pend <= 1'b1;
      if (got)       pend <= 1'b0;
      case (st)
        W_IDLE: if (req_valid) begin
          sel_q <= req_sel;
          off_q <= req_off;
          if (req_sel > seg_tbl_len) begin
            fc_q <= FC_TRAP;
            st   <= W_DONE;
          end else begin
            fc_q <= FC_NONE;
            st   <= W_LIMIT;
          end
        end
        W_LIMIT: if (got) begin
          if (off_q > mem_rd_data) begin
            fc_q <= FC_LIMIT;
            st   <= W_DONE;
          end else begin
            st <= W_BASE;
          end
        end
        W_BASE: if (got) begin
          lin_q <= mem_rd_data + off_q;
          st    <= W_OUTER;
        end
        W_OUTER: if (got) begin
          if (!mem_rd_data[0]) begin
            fc_q <= FC_NP_O;
            st   <= W_DONE;
          end else begin
            tbl_q <= {mem_rd_data[AW-1:PG_W], {PG_W{1'b0}}};
            st    <= W_INNER;
          end
        end
        W_INNER: if (got) begin
          if (!mem_rd_data[0]) begin
            fc_q <= FC_NP_I;
          end else begin
            pa_q <= {mem_rd_data[AW-1:PG_W], lin_q[PG_W-1:0]};
          end
          st <= W_DONE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_page_walker_chk.sv
module seg_page_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [2:0]    fault_code
);
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !done && !fault)); // R9
  AST_RESULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy); // R9
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R10
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_code == 3'd0)); // R10
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00)); // R5
endmodule

bind seg_page_walker seg_page_walker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .busy(busy), .done(done), .fault(fault), .fault_code(fault_code)
);

// File: tb/seg_page_walker_tb.sv
module seg_page_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [12:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [31:0] seg_tbl_base = 32'h0000_1000;
  logic [12:0] seg_tbl_len = 13'd5;
  logic [31:0] dir_base = 32'h0000_4000;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        busy, done, fault;
  logic [2:0]  fault_code;
  logic [31:0] phys_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_page_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .seg_tbl_base(seg_tbl_base), .seg_tbl_len(seg_tbl_len),
    .dir_base(dir_base), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
    .done(done), .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr)
  );

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  code;
    int          nrd;
    int          rd_base;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] mem [int unsigned];
  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int overlap = 0;
  int lat = 1;
  int cnt = 0;
  logic [31:0] rd_a = '0;

  function automatic logic [31:0] peek(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= peek(rd_a);
      end
    end
    if (mem_rd_en) begin
      if (cnt > 1) overlap++;
      rd_cnt++;
      rd_a <= mem_rd_addr;
      cnt  <= lat;
    end
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t model(logic [12:0] sel, logic [31:0] off);
    exp_t e;
    logic [31:0] d, lim, lin, o, i;
    e.pa = '0; e.code = 3'd0; e.nrd = 0; e.rd_base = 0;
    if (sel > seg_tbl_len) begin e.code = 3'd1; return e; end      // R2
    d = seg_tbl_base + {16'h0, sel, 3'b000};
    lim = peek(d); e.nrd = 1;
    if (off > lim) begin e.code = 3'd2; return e; end              // R3
    lin = peek(d + 32'd4) + off; e.nrd = 2;                         // R4
    o = peek(dir_base + {20'h0, lin[31:22], 2'b00}); e.nrd = 3;
    if (!o[0]) begin e.code = 3'd3; return e; end                  // R5
    i = peek({o[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00}); e.nrd = 4;
    if (!i[0]) begin e.code = 3'd4; return e; end                  // R6
    e.pa = {i[31:12], lin[11:0]};                                   // R7
    return e;
  endfunction

  task automatic drive(logic [12:0] sel, logic [31:0] off, bit poke);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(sel, off);
    e.rd_base = rd_cnt;
    exp_q.push_back(e);
    req_sel = sel; req_off = off; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      check(busy === 1'b1, "R9 busy", {31'h0, busy}, 32'h1);
      req_sel = 13'd2; req_off = 32'h0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && !done && !fault, "R9 idle after result",
          {29'h0, busy, done, fault}, 32'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && fault) check(1'b0, "R10 both high", 32'h3, 32'h0);
      if (done || fault) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", {31'h0, done}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(fault_code === e.code, "R2/R3/R5/R6 code", {29'h0, fault_code}, {29'h0, e.code});
          check(done === (e.code == 3'd0), "R10 done vs fault", {31'h0, done}, {31'h0, e.code == 3'd0});
          check(rd_cnt - e.rd_base == e.nrd, "R8 read count", rd_cnt - e.rd_base, e.nrd);
          if (e.code == 3'd0) check(phys_addr === e.pa, "R7 phys", phys_addr, e.pa);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R9 actual=hung expected=idle");
    finish_up();
  end

  initial begin
    // segment 2: limit 0x3FFF, base 0x0040_0000
    mem[32'h1010] = 32'h0000_3FFF; mem[32'h1014] = 32'h0040_0000;
    // segment 3: outer entry missing
    mem[32'h1018] = 32'h0000_0100; mem[32'h101C] = 32'h0080_0000;
    // segment 4: inner entry missing
    mem[32'h1020] = 32'h0000_1000; mem[32'h1024] = 32'h00C0_0000;
    // segment 5 (== length): base wraps
    mem[32'h1028] = 32'hFFFF_FFFF; mem[32'h102C] = 32'hFFFF_F000;
    mem[32'h4000] = 32'h0000_7001;
    mem[32'h4004] = 32'h0000_8003;
    mem[32'h400C] = 32'h0000_9001;
    mem[32'h7004] = 32'h0055_5001;
    mem[32'h8000] = 32'h1234_5001;
    mem[32'h800C] = 32'hABCD_E00F;

    repeat (3) @(negedge clk);
    check(!busy && !done && !fault && !mem_rd_en && fault_code == 3'd0, "R1 reset state",
          {27'h0, busy, done, fault, mem_rd_en, |fault_code}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    drive(13'd2, 32'h0000_0ABC, 1'b0);  // R7 success, lat 1
    lat = 3;
    drive(13'd2, 32'h0000_3FFF, 1'b0);  // R3 offset equal to limit
    drive(13'd2, 32'h0000_4000, 1'b0);  // R3 limit fault
    drive(13'd6, 32'h0, 1'b0);          // R2 trap
    lat = 1;
    drive(13'h1FFF, 32'h0, 1'b0);       // R2 trap, max selector
    drive(13'd5, 32'h0000_2345, 1'b0);  // R4 wrap, R2 selector equals length
    drive(13'd3, 32'h0000_0010, 1'b0);  // R5 outer not present
    lat = 3;
    drive(13'd4, 32'h0000_0004, 1'b0);  // R6 inner not present
    drive(13'd2, 32'h0000_0ABC, 1'b1);  // R9 request during walk ignored

    check(overlap == 0, "R8 overlapping reads", overlap, 32'h0);
    check(model(13'd5, 32'h2345).pa == 32'h0055_5345, "R4 model sanity",
          model(13'd5, 32'h2345).pa, 32'h0055_5345);
    finish_up();
  end
endmodule